// File: doc/BRIEF.md
# Region-Dependent Wait State Generator

This block drives the active-low wait input of an 8-bit processor with a multiplexed memory map. Each time the processor starts a memory cycle, the block looks at which region the address decoder has selected. It then holds the processor in wait for a number of clock periods fixed for that region. Program RAM is fast enough to need no stretching. A read from ROM gets one wait period. Video memory gets one period, or two when the hold input is high at the moment the cycle is recognised.

The internal stretching applies only in high-speed mode. In low-speed mode the slower memories meet their access time without help, so the internal waits are dropped. An active-low wait line from the expansion bus is combined with the internal one by an AND. Either source can therefore stall the processor, and the external line works in both speed modes and in every state of the generator.

All decisions are taken on the rising edge of `clk_i`. The clock tree supplies this input as a delayed copy of the processor clock, so that the request, read and select lines have settled before they are sampled. Address decoding, the processor, DRAM refresh and the memories are outside this block.

Top module: `region_wait_gen`

## Requirements
- R1: While `rst_ni` is low, `wait_no` equals `ext_wait_ni` whatever the other inputs are.
- R2: In high-speed mode, a read (`rd_ni` low) with `rom_sel_i` high holds `wait_no` low for exactly ROM_WAITS (default 1) clock periods. The wait starts at the first rising edge at which `mreq_ni` is low and a region is selected.
- R3: A ROM access with `rd_ni` high inserts no wait.
- R4: In high-speed mode, a video access with `vid_hold_i` low at the start edge inserts exactly VID_WAITS (default 1) wait periods.
- R5: In high-speed mode, a video access with `vid_hold_i` high at the start edge inserts exactly VID_HOLD_WAITS (default 2) wait periods. A change of `vid_hold_i` after the start edge does not change the count.
- R6: An access with only `ram_sel_i` high inserts no wait.
- R7: With `fast_mode_i` low, no internal wait is inserted for any region.
- R8: Whenever `ext_wait_ni` is low, `wait_no` is low. `wait_no` is the AND of `ext_wait_ni` and the internal active-low wait.
- R9: Each memory cycle (`mreq_ni` low) gets a single count. `mreq_ni` going high ends any running count at the next edge, and the next cycle then gets a fresh count.
- R10: The internal wait never stays low for more consecutive periods than the largest programmed count.
- R11: When several selects are high at once, ROM takes precedence over video, and video over RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Delayed copy of the processor clock; sampling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | High selects high-speed mode, in which internal waits apply |
| mreq_ni | input | 1 | Memory request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| rom_sel_i | input | 1 | Decoded ROM region select |
| vid_sel_i | input | 1 | Decoded video memory region select |
| ram_sel_i | input | 1 | Decoded program RAM region select |
| vid_hold_i | input | 1 | Requests the longer video wait when sampled at cycle start |
| ext_wait_ni | input | 1 | Wait request from the expansion bus, active low |
| wait_no | output | 1 | Wait line to the processor, active low |

## Verification
The checker assumes two things about the inputs. First, the speed mode does not change while a count is running. Second, the selects are set up by the time of the first sampling edge of a memory cycle. The properties on low-speed mode and on RAM-only cycles depend on both assumptions. The stimulus changes inputs only on falling edges. It switches mode and selects only while `mreq_ni` is high, apart from the explicit late-hold and abort cases. Those cases move only `vid_hold_i` or `mreq_ni`, which the design is required to tolerate.

// File: rtl/wait_pkg.sv
package wait_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2,
    REG_VID  = 2'd3
  } region_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/region_decode.sv
module region_decode
  import wait_pkg::*;
#(
  parameter int unsigned ROM_WAITS      = 1,
  parameter int unsigned VID_WAITS      = 1,
  parameter int unsigned VID_HOLD_WAITS = 2,
  parameter int unsigned CNT_W          = 2
) (
  input  logic             fast_mode_i,
  input  logic             rd_ni,
  input  logic             rom_sel_i,
  input  logic             vid_sel_i,
  input  logic             ram_sel_i,
  input  logic             vid_hold_i,
  output logic             any_sel_o,
  output logic [CNT_W-1:0] need_o
);
  region_e region;

  // fixed precedence: rom > vid > ram (R11)
  always_comb begin
    if (rom_sel_i)      region = REG_ROM;
    else if (vid_sel_i) region = REG_VID;
    else if (ram_sel_i) region = REG_RAM;
    else                region = REG_NONE;
  end

  assign any_sel_o = (region != REG_NONE);

  always_comb begin
    need_o = '0;
    if (fast_mode_i) begin
      unique case (region)
        REG_ROM:  need_o = rd_ni ? '0 : CNT_W'(ROM_WAITS);
        REG_VID:  need_o = vid_hold_i ? CNT_W'(VID_HOLD_WAITS) : CNT_W'(VID_WAITS);
        REG_RAM:  need_o = '0;
        default:  need_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wait_counter.sv
module wait_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreq_ni,
  input  logic             any_sel_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             int_wait_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             taken_q;
  logic             start;

  // one decision per memory cycle
  assign start = !mreq_ni && any_sel_i && !taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      taken_q <= 1'b0;
    end else if (mreq_ni) begin
      cnt_q   <= '0;
      taken_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= need_i;
      taken_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign int_wait_no = (cnt_q == '0);
endmodule

// File: rtl/region_wait_gen.sv
module region_wait_gen
  import wait_pkg::*;
#(
  parameter int unsigned ROM_WAITS      = 1,
  parameter int unsigned VID_WAITS      = 1,
  parameter int unsigned VID_HOLD_WAITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_mode_i,
  input  logic mreq_ni,
  input  logic rd_ni,
  input  logic rom_sel_i,
  input  logic vid_sel_i,
  input  logic ram_sel_i,
  input  logic vid_hold_i,
  input  logic ext_wait_ni,
  output logic wait_no
);
  localparam int unsigned MAX_WAITS = max3(ROM_WAITS, VID_WAITS, VID_HOLD_WAITS);
  localparam int unsigned CNT_W     = (MAX_WAITS < 2) ? 1 : $clog2(MAX_WAITS + 1);

  logic             any_sel;
  logic [CNT_W-1:0] need;
  logic             int_wait_n;

  region_decode #(
    .ROM_WAITS     (ROM_WAITS),
    .VID_WAITS     (VID_WAITS),
    .VID_HOLD_WAITS(VID_HOLD_WAITS),
    .CNT_W         (CNT_W)
  ) i_decode (
    .fast_mode_i(fast_mode_i),
    .rd_ni      (rd_ni),
    .rom_sel_i  (rom_sel_i),
    .vid_sel_i  (vid_sel_i),
    .ram_sel_i  (ram_sel_i),
    .vid_hold_i (vid_hold_i),
    .any_sel_o  (any_sel),
    .need_o     (need)
  );

  wait_counter #(
    .CNT_W(CNT_W)
  ) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mreq_ni    (mreq_ni),
    .any_sel_i  (any_sel),
    .need_i     (need),
    .int_wait_no(int_wait_n)
  );

  assign wait_no = int_wait_n & ext_wait_ni;
endmodule

// File: rtl/region_wait_chk.sv
module region_wait_chk #(
  parameter int unsigned MAX_WAITS = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_mode_i,
  input logic mreq_ni,
  input logic rom_sel_i,
  input logic vid_sel_i,
  input logic ram_sel_i,
  input logic ext_wait_ni,
  input logic wait_no,
  input logic int_wait_n
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_run_q <= '0;
    else if (!int_wait_n) low_run_q <= (low_run_q == 8'hff) ? low_run_q : low_run_q + 8'd1;
    else                  low_run_q <= '0;
  end

  assert_ext_forces_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_wait_ni |-> !wait_no);

  assert_ram_no_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && ram_sel_i && !rom_sel_i && !vid_sel_i && int_wait_n) |=> int_wait_n);

  assert_slow_no_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_mode_i && int_wait_n) |=> int_wait_n);

  assert_release_on_mreq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |=> int_wait_n);

  assert_run_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run_q <= 8'(MAX_WAITS));
endmodule

bind region_wait_gen region_wait_chk #(.MAX_WAITS(MAX_WAITS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fast_mode_i(fast_mode_i),
  .mreq_ni    (mreq_ni),
  .rom_sel_i  (rom_sel_i),
  .vid_sel_i  (vid_sel_i),
  .ram_sel_i  (ram_sel_i),
  .ext_wait_ni(ext_wait_ni),
  .wait_no    (wait_no),
  .int_wait_n (int_wait_n)
);

// File: tb/test_region_wait_gen.sv
`timescale 1ns/1ps
module test_region_wait_gen;
  localparam int ROM_W = 1;
  localparam int VID_W = 1;
  localparam int HLD_W = 2;
  localparam int WIN   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_mode_i = 1'b1;
  logic mreq_ni = 1'b1;
  logic rd_ni = 1'b1;
  logic rom_sel_i = 1'b0;
  logic vid_sel_i = 1'b0;
  logic ram_sel_i = 1'b0;
  logic vid_hold_i = 1'b0;
  logic ext_wait_ni = 1'b1;
  logic wait_no;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  region_wait_gen #(.ROM_WAITS(ROM_W), .VID_WAITS(VID_W), .VID_HOLD_WAITS(HLD_W)) i_region_wait_gen (
    .clk_i(clk), .rst_ni(rst_ni), .fast_mode_i(fast_mode_i), .mreq_ni(mreq_ni),
    .rd_ni(rd_ni), .rom_sel_i(rom_sel_i), .vid_sel_i(vid_sel_i), .ram_sel_i(ram_sel_i),
    .vid_hold_i(vid_hold_i), .ext_wait_ni(ext_wait_ni), .wait_no(wait_no)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreq_ni = 1'b1; rd_ni = 1'b1;
    rom_sel_i = 1'b0; vid_sel_i = 1'b0; ram_sel_i = 1'b0; vid_hold_i = 1'b0;
    @(negedge clk);
  endtask

  // sel bits: [2]=rom [1]=vid [0]=ram
  task automatic count_lows(output int lows);
    lows = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (!wait_no) lows++;
    end
  endtask

  task automatic access(input logic fast, input logic [2:0] sel, input logic rd,
                        input logic hold, output int lows);
    @(negedge clk);
    fast_mode_i = fast;
    @(negedge clk);
    rom_sel_i = sel[2]; vid_sel_i = sel[1]; ram_sel_i = sel[0];
    rd_ni = ~rd; vid_hold_i = hold; mreq_ni = 1'b0;
    count_lows(lows);
    idle();
  endtask

  function automatic int expect_waits(logic fast, logic [2:0] sel, logic rd, logic hold);
    if (!fast)  return 0;
    if (sel[2]) return rd ? ROM_W : 0;
    if (sel[1]) return hold ? HLD_W : VID_W;
    return 0;
  endfunction

  function automatic string req_of(logic fast, logic [2:0] sel, logic rd, logic hold);
    if (!fast)           return "R7 slow mode";
    if (sel[2] && rd)    return "R2 rom read";
    if (sel[2])          return "R3 rom write";
    if (sel[1] && hold)  return "R5 video hold";
    if (sel[1])          return "R4 video";
    if (sel[0])          return "R6 ram";
    return "R6 no select";
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lows;
    // R1: reset state, request active during reset
    mreq_ni = 1'b0; vid_sel_i = 1'b1; vid_hold_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset wait high", int'(wait_no), 1);
    ext_wait_ni = 1'b0; #1;
    check("R1 reset follows ext", int'(wait_no), 0);
    ext_wait_ni = 1'b1;
    mreq_ni = 1'b1; vid_sel_i = 1'b0; vid_hold_i = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    idle();

    // sweep: mode x select x read x hold, including multi-select (R11)
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 8; s++)
        for (int r = 0; r < 2; r++)
          for (int h = 0; h < 2; h++) begin
            access(logic'(f), 3'(s), logic'(r), logic'(h), lows);
            check((s == 3 || s > 4) ? {"R11 ", req_of(logic'(f), 3'(s), logic'(r), logic'(h))}
                                    : req_of(logic'(f), 3'(s), logic'(r), logic'(h)),
                  lows, expect_waits(logic'(f), 3'(s), logic'(r), logic'(h)));
          end

    // R2: rom wait begins right after the start edge
    fast_mode_i = 1'b1;
    @(negedge clk);
    rom_sel_i = 1'b1; rd_ni = 1'b0; mreq_ni = 1'b0;
    @(negedge clk);
    check("R2 rom first period low", int'(wait_no), 0);
    @(negedge clk);
    check("R2 rom released", int'(wait_no), 1);
    idle();

    // R5: hold raised after start does not lengthen the video wait
    @(negedge clk);
    vid_sel_i = 1'b1; vid_hold_i = 1'b0; mreq_ni = 1'b0;
    @(negedge clk);
    lows = wait_no ? 0 : 1;
    vid_hold_i = 1'b1;
    for (int k = 0; k < WIN - 1; k++) begin
      @(negedge clk);
      if (!wait_no) lows++;
    end
    check("R5 late hold ignored", lows, VID_W);
    // R5: hold dropped after start does not shorten it
    idle();
    @(negedge clk);
    vid_sel_i = 1'b1; vid_hold_i = 1'b1; mreq_ni = 1'b0;
    @(negedge clk);
    lows = wait_no ? 0 : 1;
    vid_hold_i = 1'b0;
    for (int k = 0; k < WIN - 1; k++) begin
      @(negedge clk);
      if (!wait_no) lows++;
    end
    check("R5 early hold kept", lows, HLD_W);
    idle();

    // R9: abort mid-count, then fresh count
    @(negedge clk);
    vid_sel_i = 1'b1; vid_hold_i = 1'b1; mreq_ni = 1'b0;
    @(negedge clk);
    check("R9 count running", int'(wait_no), 0);
    mreq_ni = 1'b1;
    @(negedge clk);
    check("R9 abort releases", int'(wait_no), 1);
    mreq_ni = 1'b0;
    count_lows(lows);
    check("R9 fresh count", lows, HLD_W);
    // R9: mreq held low long after, no second count
    count_lows(lows);
    check("R9 single count per cycle", lows, 0);
    idle();

    // R8: external wait alone and over a ram access
    @(negedge clk);
    ext_wait_ni = 1'b0; #1;
    check("R8 ext idle", int'(wait_no), 0);
    ram_sel_i = 1'b1; mreq_ni = 1'b0;
    count_lows(lows);
    check("R8 ext over ram", lows, WIN);
    ext_wait_ni = 1'b1; #1;
    check("R8 ext released", int'(wait_no), 1);
    idle();
    // R8: ext combined with video count (union of both)
    @(negedge clk);
    vid_sel_i = 1'b1; vid_hold_i = 1'b1; mreq_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ext_wait_ni = 1'b0;
    @(negedge clk);
    check("R8 ext extends wait", int'(wait_no), 0);
    ext_wait_ni = 1'b1; #1;
    check("R10 released after count", int'(wait_no), 1);
    idle();
    // R8: ext in slow mode
    fast_mode_i = 1'b0;
    @(negedge clk);
    ext_wait_ni = 1'b0; #1;
    check("R8 ext slow mode", int'(wait_no), 0);
    ext_wait_ni = 1'b1;
    idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule